// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block watches 32 already-synchronised GPIO input pins and turns chosen pin activity into interrupt requests. Each pin has a 4-bit sense code. The code selects what counts as an event for that pin: a rising edge, a falling edge, either edge, a high level or a low level. When an event occurs, the pin's raw pending bit is set, but only if the pin's accept bit allows it. Each raw bit is then ANDed with a per-pin enable bit to form the masked status.

Two request lines leave the block. One covers pins 0 to 15 and the other covers pins 16 to 31. Each line is the OR of the masked status bits in its half.

Software uses a small register port with one write per cycle and a combinational read. Through this port it sets the accept mask, sets and clears enable bits with strobes, reads the raw and masked pending vectors, clears pending bits by writing ones, and programs the sense codes.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, every readable register reads 0 and both request lines are low. The previous-sample register of every pin is also 0.
- R2: The accept mask is read/write at 0x00. A pin's event sets its raw bit only in a cycle in which its accept bit is 1. Unmapped addresses read 0.
- R3: Writing ones to 0x04 sets those enable bits. Writing ones to 0x08 clears them. The enable vector reads back at 0x0C.
- R4: 0x10 reads the raw pending vector. 0x14 reads the raw vector ANDed with the enable vector.
- R5: Writing ones to 0x18 clears those raw bits. Zero bits leave their raw bits unchanged, and no raw bit falls without such a write.
- R6: Sense registers sit at 0x20, 0x24, 0x28 and 0x2C. Pin n uses register n/8, bits 4*(n mod 8)+3 down to 4*(n mod 8). All 32 bits read back as written.
- R7: Low three code bits = 0 (rising): a sample of 1 after a sample of 0 sets the raw bit, and the bit stays set after the pin returns low.
- R8: Code 1 (falling): a sample of 0 after a sample of 1 sets the raw bit, and a rising edge does not.
- R9: Code 2 (high level) and code 3 (low level) set the raw bit in every cycle the level is present. The event wins over a clear in the same cycle, so a clear while the level holds leaves the bit at 1.
- R10: Code 4 (both edges): either transition sets the raw bit.
- R11: Low three bits of 5, 6 or 7 detect nothing. Bit 3 of a code is stored but has no effect on detection.
- R12: The low request line is the OR of masked bits 15..0, and the high request line is the OR of masked bits 31..16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| pinIn | input | 32 | Synchronised pin levels |
| irqLow | output | 1 | Request for pins 0..15 |
| irqHigh | output | 1 | Request for pins 16..31 |

## Verification
The assertions assume that a write strobe carries exactly one address per cycle, and that pin levels are stable, synchronous samples taken at the clock edge. The enable and clear properties therefore check only the single register named in the previous cycle. The stimulus changes pins and register inputs only on the falling clock edge and never issues two writes at once. It also stays at the default width of 32 pins, so the bit positions named in the requirements apply.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int PINS_PER_SENSE = 8;
  localparam int MAX_SENSE_REGS = DATA_W / PINS_PER_SENSE;

  localparam logic [ADDR_W-1:0] ADDR_ACCEPT     = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_EN_SET     = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_EN_CLR     = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_EN_READ    = 8'h0C;
  localparam logic [ADDR_W-1:0] ADDR_RAW        = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_MASKED     = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_PEND_CLR   = 8'h18;
  localparam logic [ADDR_W-1:0] ADDR_SENSE_BASE = 8'h20;

  typedef enum logic [2:0] {
    SENSE_RISE = 3'd0,
    SENSE_FALL = 3'd1,
    SENSE_HIGH = 3'd2,
    SENSE_LOW  = 3'd3,
    SENSE_BOTH = 3'd4
  } senseKind_e;

  typedef struct packed {
    logic                      acceptWe;
    logic                      enSet;
    logic                      enClr;
    logic                      pendClr;
    logic [MAX_SENSE_REGS-1:0] senseWe;
    logic [DATA_W-1:0]         wdata;
  } ctrlStrobes_t;

  function automatic logic detectEvent(input logic [2:0] kind,
                                       input logic cur, input logic prev);
    logic hit;
    case (kind)
      SENSE_RISE: hit = cur & ~prev;
      SENSE_FALL: hit = ~cur & prev;
      SENSE_HIGH: hit = cur;
      SENSE_LOW:  hit = ~cur;
      SENSE_BOTH: hit = cur ^ prev;
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/gis_ctrl.sv
module gis_ctrl
  import gis_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int NUM_SENSE = NUM_PINS / PINS_PER_SENSE
) (
  input  logic                              regWe,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [DATA_W-1:0]                 regWdata,
  input  logic [NUM_PINS-1:0]               acceptMask,
  input  logic [NUM_PINS-1:0]               enMask,
  input  logic [NUM_PINS-1:0]               rawPend,
  input  logic [NUM_PINS-1:0]               maskedPend,
  input  logic [NUM_SENSE-1:0][DATA_W-1:0]  senseRegs,
  output ctrlStrobes_t                      strobes,
  output logic [DATA_W-1:0]                 regRdata
);
  // Write decode: one address per cycle becomes one strobe.
  always_comb begin
    strobes = '0;
    strobes.wdata = regWdata;
    if (regWe) begin
      case (regAddr)
        ADDR_ACCEPT:   strobes.acceptWe = 1'b1;
        ADDR_EN_SET:   strobes.enSet    = 1'b1;
        ADDR_EN_CLR:   strobes.enClr    = 1'b1;
        ADDR_PEND_CLR: strobes.pendClr  = 1'b1;
        default: ;
      endcase
      for (int k = 0; k < NUM_SENSE; k++) begin
        if (regAddr == ADDR_SENSE_BASE + ADDR_W'(4 * k))
          strobes.senseWe[k] = 1'b1;
      end
    end
  end

  // Read mux, combinational on the address.
  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_ACCEPT:  regRdata = DATA_W'(acceptMask);
      ADDR_EN_READ: regRdata = DATA_W'(enMask);
      ADDR_RAW:     regRdata = DATA_W'(rawPend);
      ADDR_MASKED:  regRdata = DATA_W'(maskedPend);
      default: ;
    endcase
    for (int k = 0; k < NUM_SENSE; k++) begin
      if (regAddr == ADDR_SENSE_BASE + ADDR_W'(4 * k))
        regRdata = senseRegs[k];
    end
  end
endmodule

// File: rtl/gis_datapath.sv
module gis_datapath
  import gis_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int NUM_SENSE = NUM_PINS / PINS_PER_SENSE,
  localparam int HALF = NUM_PINS / 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobes_t                      strobes,
  input  logic [NUM_PINS-1:0]               pinIn,
  output logic [NUM_PINS-1:0]               acceptMask,
  output logic [NUM_PINS-1:0]               enMask,
  output logic [NUM_PINS-1:0]               rawPend,
  output logic [NUM_PINS-1:0]               maskedPend,
  output logic [NUM_SENSE-1:0][DATA_W-1:0]  senseRegs,
  output logic                              irqLow,
  output logic                              irqHigh
);
  logic [NUM_PINS-1:0] prevPin;
  logic [NUM_PINS-1:0] eventHit;
  logic [NUM_PINS-1:0] wBits;
  logic [NUM_PINS-1:0] clrBits;

  assign wBits   = strobes.wdata[NUM_PINS-1:0];
  assign clrBits = strobes.pendClr ? wBits : '0;

  // Sense code storage, one register per group of eight pins.
  for (genvar k = 0; k < NUM_SENSE; k++) begin : g_sense
    always_ff @(posedge clk) begin
      if (!rstN)                   senseRegs[k] <= '0;
      else if (strobes.senseWe[k]) senseRegs[k] <= strobes.wdata;
    end
  end

  // Per-pin detector selected by the low three bits of its field.
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int REG_IDX = n / PINS_PER_SENSE;
    localparam int SHIFT   = 4 * (n % PINS_PER_SENSE);
    assign eventHit[n] = detectEvent(senseRegs[REG_IDX][SHIFT +: 3],
                                     pinIn[n], prevPin[n]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPin    <= '0;
      acceptMask <= '0;
      enMask     <= '0;
      rawPend    <= '0;
    end else begin
      prevPin <= pinIn;
      if (strobes.acceptWe) acceptMask <= wBits;
      if (strobes.enSet)    enMask <= enMask | wBits;
      else if (strobes.enClr) enMask <= enMask & ~wBits;
      // New events take priority over a clear of the same bit.
      rawPend <= (rawPend & ~clrBits) | (eventHit & acceptMask);
    end
  end

  assign maskedPend = rawPend & enMask;
  assign irqLow     = |maskedPend[HALF-1:0];
  assign irqHigh    = |maskedPend[NUM_PINS-1:HALF];
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gis_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [31:0]       pinIn,
  output logic              irqLow,
  output logic              irqHigh
);
  localparam int NUM_SENSE = NUM_PINS / PINS_PER_SENSE;

  ctrlStrobes_t                      strobes;
  logic [NUM_PINS-1:0]               acceptMask;
  logic [NUM_PINS-1:0]               enMask;
  logic [NUM_PINS-1:0]               rawPend;
  logic [NUM_PINS-1:0]               maskedPend;
  logic [NUM_SENSE-1:0][DATA_W-1:0]  senseRegs;

  gis_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .acceptMask (acceptMask),
    .enMask     (enMask),
    .rawPend    (rawPend),
    .maskedPend (maskedPend),
    .senseRegs  (senseRegs),
    .strobes    (strobes),
    .regRdata   (regRdata)
  );

  gis_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pinIn      (pinIn[NUM_PINS-1:0]),
    .acceptMask (acceptMask),
    .enMask     (enMask),
    .rawPend    (rawPend),
    .maskedPend (maskedPend),
    .senseRegs  (senseRegs),
    .irqLow     (irqLow),
    .irqHigh    (irqHigh)
  );
endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk
  import gis_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int HALF = NUM_PINS / 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [7:0]          regAddr,
  input logic [31:0]         regWdata,
  input logic [NUM_PINS-1:0] rawPend,
  input logic [NUM_PINS-1:0] enMask,
  input logic [NUM_PINS-1:0] acceptMask,
  input logic                irqLow,
  input logic                irqHigh
);
  // R12
  irq_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqLow == |(rawPend[HALF-1:0] & enMask[HALF-1:0]));

  // R12
  irq_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqHigh == |(rawPend[NUM_PINS-1:HALF] & enMask[NUM_PINS-1:HALF]));

  // R2
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawPend & ~$past(rawPend) & ~$past(acceptMask)) == '0);

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_EN_SET) |=>
      ((enMask & $past(regWdata[NUM_PINS-1:0])) == $past(regWdata[NUM_PINS-1:0])));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_EN_CLR) |=>
      ((enMask & $past(regWdata[NUM_PINS-1:0])) == '0));

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == ADDR_PEND_CLR) |=> (($past(rawPend) & ~rawPend) == '0));
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .rawPend    (rawPend),
  .enMask     (enMask),
  .acceptMask (acceptMask),
  .irqLow     (irqLow),
  .irqHigh    (irqHigh)
);

// File: tb/gpio_irq_sense_tb.sv
`timescale 1ns/1ps
module gpio_irq_sense_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [7:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic [31:0] pinIn;
  logic        irqLow;
  logic        irqHigh;

  always #4 clk = ~clk;

  gpio_irq_sense u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];
  int pendingCnt = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Monitor: pops each expectation and compares it with the live outputs.
  initial begin
    forever begin
      expItem_t it;
      logic [31:0] got;
      wait (pendingCnt != 0);
      #1;
      it = sbQ.pop_front();
      got = it.isIrq ? {30'b0, irqHigh, irqLow} : regRdata;
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
      pendingCnt--;
    end
  end

  task automatic pushExp(input bit isIrq, input logic [31:0] exp, input string tag);
    expItem_t it;
    it.isIrq = isIrq;
    it.exp = exp;
    it.tag = tag;
    sbQ.push_back(it);
    pendingCnt++;
    wait (pendingCnt == 0);
  endtask

  task automatic expectReg(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    pushExp(1'b0, exp, tag);
  endtask

  task automatic expectIrq(input logic [1:0] exp, input string tag);
    @(negedge clk);
    pushExp(1'b1, {30'b0, exp}, tag);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1;
    regAddr = a;
    regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    regWdata = '0;
  endtask

  task automatic setPin(input int idx, input logic v);
    @(negedge clk);
    pinIn[idx] = v;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0; pinIn = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectReg(8'h00, 32'h0, "R1 accept");
    expectReg(8'h0C, 32'h0, "R1 enable");
    expectReg(8'h10, 32'h0, "R1 raw");
    expectReg(8'h14, 32'h0, "R1 masked");
    expectReg(8'h20, 32'h0, "R1 sense0");
    expectReg(8'h2C, 32'h0, "R1 sense3");
    expectIrq(2'b00, "R1 irq");

    // R6 sense storage, all bits including bit 3 of every field
    writeReg(8'h20, 32'h89ABCDEF);
    expectReg(8'h20, 32'h89ABCDEF, "R6 sense0 readback");
    writeReg(8'h2C, 32'hF000000F);
    expectReg(8'h2C, 32'hF000000F, "R6 sense3 readback");
    writeReg(8'h2C, 32'h0);
    expectReg(8'h44, 32'h0, "R2 unmapped reads zero");
    // pin0 rise, pin1 fall, pin2 high level
    writeReg(8'h20, 32'h00000210);
    // pin8 both, pin9 code 5, pin10 high level with bit 3 set
    writeReg(8'h24, 32'h00000A54);

    // R2 accept gating: edge with accept 0 is lost
    setPin(0, 1'b1);
    expectReg(8'h10, 32'h0, "R2 event dropped while not accepted");
    setPin(0, 1'b0);
    writeReg(8'h00, 32'hFFFFFFFF);
    expectReg(8'h00, 32'hFFFFFFFF, "R2 accept readback");
    expectReg(8'h10, 32'h0, "R2 raw still clear");

    // R7 rising
    setPin(0, 1'b1);
    expectReg(8'h10, 32'h00000001, "R7 rising sets");
    setPin(0, 1'b0);
    expectReg(8'h10, 32'h00000001, "R7 held after pin returns");
    writeReg(8'h18, 32'h00000001);
    expectReg(8'h10, 32'h0, "R5 clear rising bit");

    // R8 falling
    setPin(1, 1'b1);
    expectReg(8'h10, 32'h0, "R8 rise ignored");
    setPin(1, 1'b0);
    expectReg(8'h10, 32'h00000002, "R8 falling sets");
    writeReg(8'h18, 32'h00000002);

    // R9 level high, re-asserts after clear
    setPin(2, 1'b1);
    expectReg(8'h10, 32'h00000004, "R9 high level sets");
    writeReg(8'h18, 32'h00000004);
    expectReg(8'h10, 32'h00000004, "R9 clear while high keeps bit");
    setPin(2, 1'b0);
    writeReg(8'h18, 32'h00000004);
    expectReg(8'h10, 32'h0, "R9 clear after level gone");

    // R9 level low on pin 19 (register 2, field 3)
    writeReg(8'h28, 32'h00003000);
    expectReg(8'h10, 32'h00080000, "R9 low level sets");
    setPin(19, 1'b1);
    writeReg(8'h18, 32'h00080000);
    expectReg(8'h10, 32'h0, "R9 low level cleared once high");

    // R10 both edges on pin 8
    setPin(8, 1'b1);
    expectReg(8'h10, 32'h00000100, "R10 rise sets");
    writeReg(8'h18, 32'h00000100);
    setPin(8, 1'b0);
    expectReg(8'h10, 32'h00000100, "R10 fall sets");
    writeReg(8'h18, 32'h00000100);

    // R11 code 5 detects nothing, bit 3 does not disturb level high
    setPin(9, 1'b1);
    expectReg(8'h10, 32'h0, "R11 code5 rise");
    setPin(9, 1'b0);
    expectReg(8'h10, 32'h0, "R11 code5 fall");
    setPin(10, 1'b1);
    expectReg(8'h10, 32'h00000400, "R11 bit3 ignored");

    // R3 R4 R12 enables, masked view, request lines
    expectIrq(2'b00, "R12 no enable no request");
    writeReg(8'h04, 32'h00000400);
    expectReg(8'h0C, 32'h00000400, "R3 enable set");
    expectReg(8'h14, 32'h00000400, "R4 masked");
    expectIrq(2'b01, "R12 low line");
    setPin(24, 1'b1);
    expectReg(8'h10, 32'h01000400, "R4 raw two bits");
    expectIrq(2'b01, "R12 upper not enabled");
    writeReg(8'h04, 32'h01000000);
    expectIrq(2'b11, "R12 both lines");
    writeReg(8'h08, 32'h00000400);
    expectReg(8'h0C, 32'h01000000, "R3 enable clear");
    expectReg(8'h14, 32'h01000000, "R4 masked after clear");
    expectIrq(2'b10, "R12 high line only");

    // R5 zero bits do nothing, one bits clear
    writeReg(8'h18, 32'h0);
    expectReg(8'h10, 32'h01000400, "R5 zero write no effect");
    writeReg(8'h18, 32'h01000000);
    expectReg(8'h10, 32'h00000400, "R5 clear upper bit");
    expectIrq(2'b00, "R12 lines drop");

    // R2 level not relatched once accept bit is removed
    writeReg(8'h00, 32'hFFFFFBFF);
    writeReg(8'h18, 32'h00000400);
    expectReg(8'h10, 32'h0, "R2 level blocked by accept");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule